// File: doc/BRIEF.md
# Segmented comparand loader with auto-compare

This block builds a 64-bit search key (the comparand) and a 64-bit bit-mask out of 16-bit writes arriving over a narrow data bus. A write pointer selects the 16-bit segment that each write fills. When a comparand write lands on the segment that a partition input names as the last searchable one, the block raises a one-cycle compare request for the match array next to it. A second pointer, which moves independently, selects the 16-bit segment that each read returns. Both registers can be moved by one bit per command: the comparand rotates and the mask shifts in zeros.

Software, or a sequencer, loads a key one segment after another and the compare starts without a separate command. The same key can then be rotated and searched again. The mask can be walked across the word one bit at a time.

Top module: `cmp_seg_loader`

## Requirements
- R1: After a synchronous reset, both pointers are 0. The comparand, the mask and `rd_data` read all zeros, and `cmp_req` is low.
- R2: Each accepted write stores `wr_data` into the segment at the write pointer of the register that `wr_dst` selects (0 selects the comparand, 1 selects the mask). Segment 0 is bits 15:0 and segment k is bits 16k+15:16k. The write pointer then advances by one and wraps from 3 to 0.
- R3: `cmp_req` is high for exactly the cycle after an accepted comparand write whose write pointer equalled `part_sel`. It is low after every other cycle, including every mask write.
- R4: On `rd_en`, `rd_data` presents, in the next cycle, the segment at the read pointer of the register that `rd_src` selects (0 selects the comparand, 1 selects the mask), taken before any write in that same cycle. The read pointer then advances and wraps from 3 to 0. Without `rd_en`, `rd_data` holds its value and the read pointer does not move.
- R5: With `cmp_rot_l` alone, the comparand becomes {c[62:0], c[63]}. With `cmp_rot_r` alone, it becomes {c[0], c[63:1]}.
- R6: With `msk_shl` alone, the mask becomes {m[62:0], 0}. With `msk_shr` alone, it becomes {0, m[63:1]}.
- R7: When both direction inputs of a register are high, that register keeps its value. When an accepted write targets a register in the same cycle as its move command, the write takes effect and the move is ignored.
- R8: `cnt_clr` returns both pointers to 0. A write or a read in the same cycle is ignored, so that no register, no `rd_data` and no `cmp_req` changes because of it. A move command in that cycle still applies.
- R9: The write pointer is shared by both destinations. A write to the mask leaves the comparand unchanged, and a write to the comparand leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Return both segment pointers to 0 |
| part_sel | input | 2 | Index of the last searchable segment (terminal count) |
| wr_en | input | 1 | Segment write strobe |
| wr_dst | input | 1 | Write target: 0 comparand, 1 mask |
| wr_data | input | 16 | Segment write data |
| rd_en | input | 1 | Segment read strobe |
| rd_src | input | 1 | Read source: 0 comparand, 1 mask |
| rd_data | output | 16 | Registered read segment |
| cmp_rot_l | input | 1 | Rotate comparand left by one bit |
| cmp_rot_r | input | 1 | Rotate comparand right by one bit |
| msk_shl | input | 1 | Shift mask left by one bit, filling with 0 |
| msk_shr | input | 1 | Shift mask right by one bit, filling with 0 |
| cmp_word | output | 64 | Current comparand |
| mask_word | output | 64 | Current mask |
| cmp_req | output | 1 | One-cycle automatic compare request |

## Verification
The assertions rely on `rst` being held for at least one clock edge before any check matters. They also rely on `part_sel` being stable only as far as a single write needs it: it is sampled in the cycle of the write. No assumption is made about commands that conflict. The stimulus therefore deliberately drives collisions of write and move on the same register, both directions at once, and clear together with a write or a read, and relies on the reference model to define the outcome. Random sections change `part_sel` freely between writes. This covers compare requests on back-to-back writes and at every terminal count.

// File: rtl/cmp_seg_pkg.sv
package cmp_seg_pkg;

  typedef enum logic [1:0] {
    MV_NONE  = 2'd0,
    MV_LEFT  = 2'd1,
    MV_RIGHT = 2'd2
  } move_e;

  // Exactly one direction requested -> move; none or both -> hold.
  function automatic move_e move_dec(input logic left, input logic right);
    if (left && !right)      return MV_LEFT;
    else if (right && !left) return MV_RIGHT;
    else                     return MV_NONE;
  endfunction

endpackage

// File: rtl/seg_ptr.sv
module seg_ptr #(
  parameter int NSEG  = 4,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSEG - 1);
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr)  idx <= '0;
    else if (adv)    idx <= (idx == LAST) ? '0 : idx + ONE;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr && adv && idx == LAST) |=> (idx == '0));                // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && adv && idx != LAST) |=> (idx == $past(idx) + ONE));  // R2
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (idx == '0));                                          // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> $stable(idx));                              // R4

endmodule

// File: rtl/seg_move_reg.sv
module seg_move_reg
  import cmp_seg_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int NSEG   = 4,
  parameter bit ROTATE = 1'b1,
  localparam int REG_W = BUS_W * NSEG,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [IDX_W-1:0] ld_seg,
  input  logic [BUS_W-1:0] ld_data,
  input  move_e            mv,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] moved_l, moved_r;

  generate
    if (ROTATE) begin : g_rot
      assign moved_l = {q[REG_W-2:0], q[REG_W-1]};
      assign moved_r = {q[0], q[REG_W-1:1]};
    end else begin : g_shift
      assign moved_l = {q[REG_W-2:0], 1'b0};
      assign moved_r = {1'b0, q[REG_W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ld) begin
      q[ld_seg*BUS_W +: BUS_W] <= ld_data;
    end else begin
      case (mv)
        MV_LEFT:  q <= moved_l;
        MV_RIGHT: q <= moved_r;
        default:  q <= q;
      endcase
    end
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld && mv == MV_NONE) |=> $stable(q));                        // R7

  generate
    if (ROTATE) begin : g_rot_chk
      AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
        (!ld && mv != MV_NONE) |=> ($countones(q) == $past($countones(q)))); // R5
    end else begin : g_shift_chk
      AST_SHIFT_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        (!ld && mv != MV_NONE) |=> ($countones(q) <= $past($countones(q)))); // R6
    end
  endgenerate

endmodule

// File: rtl/cmp_seg_loader.sv
module cmp_seg_loader
  import cmp_seg_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int NSEG   = 4,
  localparam int REG_W = BUS_W * NSEG,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clr,
  input  logic [IDX_W-1:0] part_sel,
  input  logic             wr_en,
  input  logic             wr_dst,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_src,
  output logic [BUS_W-1:0] rd_data,
  input  logic             cmp_rot_l,
  input  logic             cmp_rot_r,
  input  logic             msk_shl,
  input  logic             msk_shr,
  output logic [REG_W-1:0] cmp_word,
  output logic [REG_W-1:0] mask_word,
  output logic             cmp_req
);
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_ok, rd_ok, ld_cmp, ld_msk;

  assign wr_ok  = wr_en && !cnt_clr;
  assign rd_ok  = rd_en && !cnt_clr;
  assign ld_cmp = wr_ok && !wr_dst;
  assign ld_msk = wr_ok &&  wr_dst;

  seg_ptr #(.NSEG(NSEG)) u_wr_ptr (
    .clk(clk), .rst(rst), .clr(cnt_clr), .adv(wr_en), .idx(wr_idx)
  );

  seg_ptr #(.NSEG(NSEG)) u_rd_ptr (
    .clk(clk), .rst(rst), .clr(cnt_clr), .adv(rd_en), .idx(rd_idx)
  );

  seg_move_reg #(.BUS_W(BUS_W), .NSEG(NSEG), .ROTATE(1'b1)) u_cmp_reg (
    .clk(clk), .rst(rst), .ld(ld_cmp), .ld_seg(wr_idx), .ld_data(wr_data),
    .mv(move_dec(cmp_rot_l, cmp_rot_r)), .q(cmp_word)
  );

  seg_move_reg #(.BUS_W(BUS_W), .NSEG(NSEG), .ROTATE(1'b0)) u_msk_reg (
    .clk(clk), .rst(rst), .ld(ld_msk), .ld_seg(wr_idx), .ld_data(wr_data),
    .mv(move_dec(msk_shl, msk_shr)), .q(mask_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      cmp_req <= 1'b0;
    end else begin
      cmp_req <= ld_cmp && (wr_idx == part_sel);
      if (rd_ok)
        rd_data <= rd_src ? mask_word[rd_idx*BUS_W +: BUS_W]
                          : cmp_word[rd_idx*BUS_W +: BUS_W];
    end
  end

  AST_REQ_NEEDS_CMP_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmp_req |-> $past(wr_en && !cnt_clr && !wr_dst));              // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));                                  // R4
  AST_CLR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> !cmp_req);                                         // R8
  AST_MSK_WRITE_KEEPS_CMP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_dst && !cmp_rot_l && !cmp_rot_r) |=> $stable(cmp_word)); // R9

endmodule

// File: tb/cmp_seg_loader_bench.sv
module cmp_seg_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEGS = 4;

  logic        clk = 1'b0;
  logic        rst, cnt_clr, wr_en, wr_dst, rd_en, rd_src;
  logic        cmp_rot_l, cmp_rot_r, msk_shl, msk_shr;
  logic [1:0]  part_sel;
  logic [15:0] wr_data, rd_data;
  logic [63:0] cmp_word, mask_word;
  logic        cmp_req;

  int n_checks = 0;
  int n_fail   = 0;
  string tag   = "R1";

  cmp_seg_loader u_cmp_seg_loader (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .part_sel(part_sel),
    .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data),
    .rd_en(rd_en), .rd_src(rd_src), .rd_data(rd_data),
    .cmp_rot_l(cmp_rot_l), .cmp_rot_r(cmp_rot_r),
    .msk_shl(msk_shl), .msk_shr(msk_shr),
    .cmp_word(cmp_word), .mask_word(mask_word), .cmp_req(cmp_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [63:0] m_cmp = '0, m_msk = '0;
  logic [15:0] m_rd = '0;
  logic        m_req = 1'b0;
  int          m_wp = 0, m_rp = 0;

  always @(posedge clk) begin
    logic [63:0] oc, om;
    bit wr_c, wr_m;
    oc = m_cmp; om = m_msk;
    if (rst) begin
      m_cmp = '0; m_msk = '0; m_rd = '0; m_req = 1'b0; m_wp = 0; m_rp = 0;
    end else begin
      wr_c = wr_en && !cnt_clr && !wr_dst;
      wr_m = wr_en && !cnt_clr &&  wr_dst;
      m_req = wr_c && (m_wp == int'(part_sel));
      if (wr_c) m_cmp[m_wp*16 +: 16] = wr_data;
      else if (cmp_rot_l && !cmp_rot_r) m_cmp = {oc[62:0], oc[63]};
      else if (cmp_rot_r && !cmp_rot_l) m_cmp = {oc[0], oc[63:1]};
      if (wr_m) m_msk[m_wp*16 +: 16] = wr_data;
      else if (msk_shl && !msk_shr) m_msk = {om[62:0], 1'b0};
      else if (msk_shr && !msk_shl) m_msk = {1'b0, om[63:1]};
      if (cnt_clr) begin
        m_wp = 0; m_rp = 0;
      end else begin
        if (rd_en) begin
          m_rd = rd_src ? om[m_rp*16 +: 16] : oc[m_rp*16 +: 16];
          m_rp = (m_rp + 1) % SEGS;
        end
        if (wr_en) m_wp = (m_wp + 1) % SEGS;
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("cmp_word",  cmp_word,  m_cmp);
      chk("mask_word", mask_word, m_msk);
      chk("rd_data",   {48'd0, rd_data}, {48'd0, m_rd});
      chk("cmp_req",   {63'd0, cmp_req}, {63'd0, m_req});
    end
  end

  task automatic idle();
    cnt_clr = 0; wr_en = 0; wr_dst = 0; rd_en = 0; rd_src = 0;
    cmp_rot_l = 0; cmp_rot_r = 0; msk_shl = 0; msk_shr = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    #1 idle();
  endtask

  task automatic wr(logic dst, logic [15:0] d);
    wr_en = 1; wr_dst = dst; wr_data = d; cyc();
  endtask

  task automatic rd(logic src);
    rd_en = 1; rd_src = src; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(); rst = 1; part_sel = 2'd3; wr_data = '0;
    repeat (3) @(negedge clk);
    #1 rst = 0;
    // R1: reset state
    tag = "R1"; @(negedge clk);
    chk("reset cmp_req", {63'd0, cmp_req}, 64'd0);
    chk("reset cmp_word", cmp_word, 64'd0);
    #1;
    // R2/R3: full load with terminal count 3
    tag = "R2"; wr(0, 16'h1111); wr(0, 16'h2222); wr(0, 16'h3333);
    tag = "R3"; wr(0, 16'h4444);
    chk("R3 pulse", {63'd0, cmp_req}, 64'd1);
    tag = "R2"; chk("R2 assembled", cmp_word, 64'h4444_3333_2222_1111);
    // R3: terminal count 1, pointer now 0 after wrap
    tag = "R3"; part_sel = 2'd1; wr(0, 16'hAAAA); wr(0, 16'hBBBB); cyc();
    wr(0, 16'hCCCC); wr(0, 16'hDDDD);
    // R9/R3: mask writes never request a compare
    tag = "R9"; part_sel = 2'd0;
    wr(1, 16'hF00F); wr(1, 16'h0FF0); wr(1, 16'h8001); wr(1, 16'h7FFE);
    // R4: reads, both sources, wrap
    tag = "R4";
    for (int i = 0; i < 6; i++) rd(i[0]);
    cyc(); cyc();
    rd_en = 1; rd_src = 0; wr_en = 1; wr_dst = 0; wr_data = 16'h5A5A; cyc();
    // R5: rotations
    tag = "R5";
    for (int i = 0; i < 5; i++) begin cmp_rot_l = 1; cyc(); end
    for (int i = 0; i < 7; i++) begin cmp_rot_r = 1; cyc(); end
    // R6: shifts with zero fill
    tag = "R6";
    for (int i = 0; i < 3; i++) begin msk_shl = 1; cyc(); end
    for (int i = 0; i < 70; i++) begin msk_shr = 1; cyc(); end
    wr(1, 16'hFFFF); wr(1, 16'hFFFF); wr(1, 16'hFFFF); wr(1, 16'hFFFF);
    for (int i = 0; i < 3; i++) begin msk_shl = 1; cyc(); end
    // R7: conflicting commands
    tag = "R7";
    cmp_rot_l = 1; cmp_rot_r = 1; msk_shl = 1; msk_shr = 1; cyc();
    wr_en = 1; wr_dst = 0; wr_data = 16'h1234; cmp_rot_l = 1; cyc();
    wr_en = 1; wr_dst = 1; wr_data = 16'h4321; msk_shr = 1; cyc();
    // R8: clear with write/read/moves
    tag = "R8";
    wr(0, 16'h0001); rd(0);
    cnt_clr = 1; wr_en = 1; wr_dst = 0; wr_data = 16'hDEAD;
    rd_en = 1; cmp_rot_l = 1; cyc();
    part_sel = 2'd0; wr(0, 16'hBEEF); rd(0);
    // Random mix
    tag = "MIX";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      part_sel = 2'(r); wr_en = r[2]; wr_dst = r[3]; wr_data = 16'($urandom);
      rd_en = r[4]; rd_src = r[5];
      cmp_rot_l = r[6] & r[7]; cmp_rot_r = r[8] & r[9];
      msk_shl = r[10] & r[11]; msk_shr = r[12] & r[13];
      cnt_clr = (r[18:14] == 5'd0);
      cyc();
    end
    cyc(); cyc();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule